// File: doc/BRIEF.md
# Paired Capture/Compare Timer

This block holds two 16-bit timer channels that share one register port. Each channel has an up-counter, a compare value, a capture latch and a two-bit sticky event register. A channel counts on a clock it selects from four sources: the partner channel's match pulse (cascade), every system clock, every sixteenth system clock, or falling edges on an external pin. An 8-bit prescaler sits in front of the counter. An external gate pin can hold counting off. A match between the counter and the compare value, or an edge on the capture pin, sets an event bit. The event bits drive a level interrupt for each channel, and software clears them by writing ones.

Software uses the register port, which has no back-pressure. A write happens on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr` and has no side effects. Bit 3 of the address picks the channel and bits 2:0 pick the register: 0 control, 1 compare, 2 capture (read-only, writes are dropped), 3 counter, 4 events. Addresses 5 to 7 read as zero. The external pins are asynchronous. Each passes through a two-stage synchronizer before edge detection, so a pin level must be held for at least two clock cycles.

Top module: `tmr_pair`

## Requirements
- R1: After reset the control register, the capture register, the counter and the event register read 0, the compare register reads 0xFFFF, and both interrupts are low.
- R2: Control bit 0 enables counting. Bits 2:1 select the count source. When the source is 01 (every system clock), the counter advances by one every (P+1) clocks, where P is control bits 15:8. Reading the counter never changes its value or its pace.
- R3: Writing the counter loads the written value and restarts the prescaler from zero. The next increment therefore comes P+1 qualified ticks after the write.
- R4: Source 10 gives one tick every 16 system clocks, from a free-running divider.
- R5: Source 11 gives one tick per falling edge of the synchronized external count pin. Rising edges are not counted.
- R6: Source 00 gives channel 0 one tick per match pulse from channel 1. On channel 1, source 00 supplies no tick and the counter holds.
- R7: When control bit 3 is 1, counting happens only while the synchronized gate pin is high. When bit 3 is 0, the gate pin is ignored.
- R8: While control bit 0 is 0, the counter changes only through a counter write.
- R9: Event bit 0 (match) sets when an increment brings the counter equal to the compare value, whatever the state of control bit 4. Writing the counter to the compare value does not set it. The counter keeps counting past the compare value and wraps from 0xFFFF to 0.
- R10: Control bits 6:5 choose the capture edge: 00 none, 01 rising, 10 falling, 11 both. On a chosen edge of the synchronized capture pin, the counter value is copied to the capture register and event bit 1 (capture) sets. With 00, neither changes.
- R11: Writing the event register clears each bit written as 1 and leaves bits written as 0 unchanged. Both bits can be cleared in one write. A set in the same cycle wins over a clear.
- R12: The channel interrupt is (match AND control bit 4) OR capture. It stays high until every bit that drives it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Bit 3 channel, bits 2:0 register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| ext_tick | input | 2 | External count pins, one per channel |
| ext_gate | input | 2 | Gate pins, one per channel |
| ext_capture | input | 2 | Capture pins, one per channel |
| irq | output | 2 | Level interrupt per channel |
| match_pulse | output | 2 | One-cycle pulse per channel on a match event |

## Verification
The bench sweeps prescaler values and reads the counter every cycle. A prescaler off by one, or a read that disturbs counting, shows up as a wrong count within a few reads. Counter writes land in the middle of a prescale period, so a prescaler that is not restarted makes the next increment come early. The bench loads the counter to exactly the compare value and also steps it onto that value, so a compare on the register instead of on the increment either misses the match or flags a write. It sweeps every capture-edge mode against both pin edges, clears event bits one at a time and both together, and checks that channel 1 stays frozen when it selects cascade. A design that mixed up those cases would latch the wrong value, drop the interrupt too early, or let channel 1 run.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W     = 16;
  localparam int PRESC_W    = 8;
  localparam int NCH        = 2;
  localparam int CH_W       = $clog2(NCH);
  localparam int REG_W      = 3;
  localparam int ADDR_W     = CH_W + REG_W;
  localparam int EVT_W      = 2;
  localparam int EVT_MATCH  = 0;
  localparam int EVT_CAPT   = 1;
  localparam int MODE_PAD_W = DATA_W - PRESC_W - 7;

  localparam logic [REG_W-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_W-1:0] REG_CMP  = 3'd1;
  localparam logic [REG_W-1:0] REG_CAPT = 3'd2;
  localparam logic [REG_W-1:0] REG_CNT  = 3'd3;
  localparam logic [REG_W-1:0] REG_EVT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'b00,
    SRC_SYS     = 2'b01,
    SRC_SYS16   = 2'b10,
    SRC_PIN     = 2'b11
  } tick_src_e;

  typedef enum logic [1:0] {
    CAPT_OFF  = 2'b00,
    CAPT_RISE = 2'b01,
    CAPT_FALL = 2'b10,
    CAPT_ANY  = 2'b11
  } capt_edge_e;

  typedef struct packed {
    logic [PRESC_W-1:0]    presc;
    logic [MODE_PAD_W-1:0] pad;
    capt_edge_e            capt_edge;
    logic                  match_ie;
    logic                  gate_en;
    tick_src_e             src;
    logic                  run;
  } ctrl_t;
endpackage

// File: rtl/tmr_pin_cond.sv
`timescale 1ns/1ps
module tmr_pin_cond #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              cmp_wr,
  input  logic              cnt_wr,
  input  logic              evt_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              casc_tick,
  input  logic              sys16_tick,
  input  logic              pin_fall,
  input  logic              gate_lvl,
  input  logic              capt_rise,
  input  logic              capt_fall,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] capt_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [EVT_W-1:0]  evt_o,
  output logic              run_o,
  output logic              irq_o,
  output logic              match_o
);
  ctrl_t               ctrl_q;
  logic [DATA_W-1:0]   cmp_q, capt_q, cnt_q, cnt_inc;
  logic [PRESC_W-1:0]  ps_q;
  logic [EVT_W-1:0]    evt_q, evt_set;
  logic                src_tick, qual_tick, ps_wrap, step, match_hit, capt_hit, match_q;

  // count source selection
  always_comb begin
    case (ctrl_q.src)
      SRC_CASCADE: src_tick = casc_tick;
      SRC_SYS:     src_tick = 1'b1;
      SRC_SYS16:   src_tick = sys16_tick;
      default:     src_tick = pin_fall;
    endcase
  end

  assign qual_tick = ctrl_q.run && src_tick && (!ctrl_q.gate_en || gate_lvl);
  assign ps_wrap   = (ps_q >= ctrl_q.presc);
  assign step      = qual_tick && ps_wrap && !cnt_wr;
  assign cnt_inc   = cnt_q + 1'b1;
  assign match_hit = step && (cnt_inc == cmp_q);

  always_comb begin
    case (ctrl_q.capt_edge)
      CAPT_RISE: capt_hit = capt_rise;
      CAPT_FALL: capt_hit = capt_fall;
      CAPT_ANY:  capt_hit = capt_rise | capt_fall;
      default:   capt_hit = 1'b0;
    endcase
  end

  always_comb begin
    evt_set            = '0;
    evt_set[EVT_MATCH] = match_hit;
    evt_set[EVT_CAPT]  = capt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_q   <= '1;
      capt_q  <= '0;
      cnt_q   <= '0;
      ps_q    <= '0;
      evt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata);
      if (cmp_wr)  cmp_q  <= wdata;
      if (cnt_wr) begin
        cnt_q <= wdata;
        ps_q  <= '0;
      end else if (qual_tick) begin
        ps_q <= ps_wrap ? '0 : ps_q + 1'b1;
        if (ps_wrap) cnt_q <= cnt_inc;
      end
      if (capt_hit) capt_q <= cnt_q;
      for (int b = 0; b < EVT_W; b++)
        evt_q[b] <= evt_set[b] | (evt_q[b] & ~(evt_wr & wdata[b]));
      match_q <= match_hit;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cmp_o   = cmp_q;
  assign capt_o  = capt_q;
  assign cnt_o   = cnt_q;
  assign evt_o   = evt_q;
  assign run_o   = ctrl_q.run;
  assign match_o = match_q;
  assign irq_o   = (evt_q[EVT_MATCH] & ctrl_q.match_ie) | evt_q[EVT_CAPT];
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int SYS_DIV_LOG2 = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ext_tick,
  input  logic [NCH-1:0]    ext_gate,
  input  logic [NCH-1:0]    ext_capture,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    match_pulse
);
  localparam int PIN_TICK = 0;
  localparam int PIN_GATE = 1;
  localparam int PIN_CAPT = 2;
  localparam int NPIN     = 3;

  logic [NCH-1:0][DATA_W-1:0] ctrl_w, cmp_w, capt_w, cnt_w;
  logic [NCH-1:0][EVT_W-1:0]  evt_w;
  logic [NCH-1:0]             run_w, casc_w;
  logic [SYS_DIV_LOG2-1:0]    div_q;
  logic                       sys16_tick;
  logic [CH_W-1:0]            sel_ch;
  logic [REG_W-1:0]           sel_reg;

  assign sel_ch  = bus_addr[ADDR_W-1:REG_W];
  assign sel_reg = bus_addr[REG_W-1:0];

  // shared divided system tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign sys16_tick = &div_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            hit;
    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic            unused_pins;

    assign hit = bus_wr && (sel_ch == CH_W'(c));

    // even channels take the odd partner's match pulse; odd channels get none
    if ((c % 2) == 0) begin : g_casc
      assign casc_w[c] = match_pulse[c+1];
    end else begin : g_nocasc
      assign casc_w[c] = 1'b0;
    end

    tmr_pin_cond #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pins (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  ({ext_capture[c], ext_gate[c], ext_tick[c]}),
      .lvl  (pin_lvl),
      .rise (pin_rise),
      .fall (pin_fall)
    );
    assign unused_pins = ^{pin_lvl[PIN_TICK], pin_lvl[PIN_CAPT], pin_rise[PIN_TICK],
                           pin_rise[PIN_GATE], pin_fall[PIN_GATE]};

    tmr_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (hit && (sel_reg == REG_CTRL)),
      .cmp_wr    (hit && (sel_reg == REG_CMP)),
      .cnt_wr    (hit && (sel_reg == REG_CNT)),
      .evt_wr    (hit && (sel_reg == REG_EVT)),
      .wdata     (bus_wdata),
      .casc_tick (casc_w[c]),
      .sys16_tick(sys16_tick),
      .pin_fall  (pin_fall[PIN_TICK]),
      .gate_lvl  (pin_lvl[PIN_GATE]),
      .capt_rise (pin_rise[PIN_CAPT]),
      .capt_fall (pin_fall[PIN_CAPT]),
      .ctrl_o    (ctrl_w[c]),
      .cmp_o     (cmp_w[c]),
      .capt_o    (capt_w[c]),
      .cnt_o     (cnt_w[c]),
      .evt_o     (evt_w[c]),
      .run_o     (run_w[c]),
      .irq_o     (irq[c]),
      .match_o   (match_pulse[c])
    );
  end

  always_comb begin
    case (sel_reg)
      REG_CTRL: bus_rdata = ctrl_w[sel_ch];
      REG_CMP:  bus_rdata = cmp_w[sel_ch];
      REG_CAPT: bus_rdata = capt_w[sel_ch];
      REG_CNT:  bus_rdata = cnt_w[sel_ch];
      REG_EVT:  bus_rdata = DATA_W'(evt_w[sel_ch]);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0][DATA_W-1:0] cnt,
  input logic [NCH-1:0][DATA_W-1:0] refv,
  input logic [NCH-1:0][DATA_W-1:0] capv,
  input logic [NCH-1:0][EVT_W-1:0]  evt,
  input logic [NCH-1:0]             irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_match_on_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[c][EVT_MATCH]) |-> (cnt[c] == $past(refv[c])));

    assert_capture_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[c][EVT_CAPT]) |-> (capv[c] == $past(cnt[c])));

    assert_clear_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(evt[c][EVT_MATCH]) || $fell(evt[c][EVT_CAPT])) |-> $past(bus_wr));

    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !bus_wr) |=> $stable(cnt[c]));

    assert_irq_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[c]) |-> $past(bus_wr));
  end
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .bus_wr(bus_wr),
  .run   (run_w),
  .cnt   (cnt_w),
  .refv  (cmp_w),
  .capv  (capt_w),
  .evt   (evt_w),
  .irq   (irq)
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  ext_tick = '0, ext_gate = '0, ext_capture = '0;
  logic [1:0]  irq, match_pulse;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CMP = 3'd1, A_CAPT = 3'd2, A_CNT = 3'd3, A_EVT = 3'd4;

  tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .ext_gate(ext_gate), .ext_capture(ext_capture), .irq(irq), .match_pulse(match_pulse)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] mk(input logic run, input logic [1:0] src, input logic gate,
                                     input logic ie, input logic [1:0] cedge, input logic [7:0] p);
    return {p, 1'b0, cedge, ie, gate, src, run};
  endfunction

  task automatic wr(input logic ch, input logic [2:0] r, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {ch, r}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic ch, input logic [2:0] r, output logic [15:0] d);
    bus_addr = {ch, r};
    #1;
    d = bus_rdata;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset values
    for (int ch = 0; ch < 2; ch++) begin
      rd(ch[0], A_CTRL, v); check("R1 ctrl", v, 16'h0000);
      rd(ch[0], A_CMP, v);  check("R1 compare", v, 16'hFFFF);
      rd(ch[0], A_CAPT, v); check("R1 capture", v, 16'h0000);
      rd(ch[0], A_CNT, v);  check("R1 counter", v, 16'h0000);
      rd(ch[0], A_EVT, v);  check("R1 events", v, 16'h0000);
    end
    check("R1 irq", {14'd0, irq}, 16'h0000);

    // R2 prescaler sweep on system clock, reading every cycle
    for (int p = 0; p < 5; p++) begin
      wr(0, A_CTRL, mk(1, 2'b01, 0, 0, 2'b00, 8'(p)));
      wr(0, A_CNT, 16'h0000);
      for (int j = 1; j <= 12; j++) begin
        cycles(1);
        rd(0, A_CNT, v);
        check("R2 sys count", v, 16'(j / (p + 1)));
      end
    end

    // R3 counter write restarts prescaler
    wr(0, A_CTRL, mk(1, 2'b01, 0, 0, 2'b00, 8'd3));
    wr(0, A_CNT, 16'h0000);
    cycles(2);
    wr(0, A_CNT, 16'd100);
    cycles(3);
    rd(0, A_CNT, v); check("R3 before wrap", v, 16'd100);
    cycles(1);
    rd(0, A_CNT, v); check("R3 first step", v, 16'd101);

    // R8 stopped counter holds
    wr(0, A_CTRL, mk(0, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'd5);
    cycles(10);
    rd(0, A_CNT, v); check("R8 hold", v, 16'd5);

    // R4 divide by sixteen
    wr(0, A_CTRL, mk(1, 2'b10, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'h0000);
    cycles(160);
    rd(0, A_CNT, v); check("R4 div16", v, 16'd10);
    wr(0, A_CTRL, mk(1, 2'b10, 0, 0, 2'b00, 8'd1));
    wr(0, A_CNT, 16'h0000);
    cycles(320);
    rd(0, A_CNT, v); check("R4 div16 presc1", v, 16'd10);

    // R9 wrap past compare 0xFFFF
    wr(0, A_CTRL, mk(1, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'hFFFE);
    cycles(1);
    rd(0, A_EVT, v); check("R9 match at FFFF", v, 16'h0001);
    cycles(1);
    rd(0, A_CNT, v); check("R9 wrap", v, 16'h0000);
    wr(0, A_CTRL, mk(0, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(0, A_EVT, 16'h0001);
    rd(0, A_EVT, v); check("R11 clear match", v, 16'h0000);

    // R9 write to compare value is not an event
    wr(0, A_CMP, 16'h0010);
    wr(0, A_CNT, 16'h0010);
    cycles(2);
    rd(0, A_EVT, v); check("R9 write equal no event", v, 16'h0000);
    wr(0, A_CTRL, mk(1, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'h000D);
    cycles(2);
    rd(0, A_EVT, v); check("R9 not yet", v, 16'h0000);
    cycles(1);
    rd(0, A_CNT, v); check("R9 count at match", v, 16'h0010);
    rd(0, A_EVT, v); check("R9 match with ie off", v, 16'h0001);
    check("R12 irq masked", {15'd0, irq[0]}, 16'd0);
    cycles(5);
    rd(0, A_CNT, v); check("R9 keeps counting", v, 16'h0015);
    wr(0, A_CTRL, mk(0, 2'b01, 0, 1, 2'b01, 8'd0));
    rd(0, A_EVT, v);
    check("R12 irq enabled", {15'd0, irq[0]}, 16'd1);

    // R11 / R12 write-one-to-clear behaviour
    wr(0, A_EVT, 16'h0000);
    rd(0, A_EVT, v); check("R11 zero write no effect", v, 16'h0001);
    ext_capture[0] = 1'b1;
    cycles(4);
    rd(0, A_EVT, v); check("R10 capture set", v, 16'h0003);
    ext_capture[0] = 1'b0;
    cycles(4);
    wr(0, A_EVT, 16'h0001);
    rd(0, A_EVT, v); check("R11 clear one", v, 16'h0002);
    check("R12 irq held by capture", {15'd0, irq[0]}, 16'd1);
    wr(0, A_EVT, 16'h0002);
    rd(0, A_EVT, v); check("R11 clear other", v, 16'h0000);
    check("R12 irq low", {15'd0, irq[0]}, 16'd0);
    wr(0, A_CTRL, mk(1, 2'b01, 0, 1, 2'b01, 8'd0));
    wr(0, A_CNT, 16'h000D);
    ext_capture[0] = 1'b1;
    cycles(4);
    ext_capture[0] = 1'b0;
    cycles(4);
    rd(0, A_EVT, v); check("R11 both set", v, 16'h0003);
    wr(0, A_EVT, 16'h0003);
    rd(0, A_EVT, v); check("R11 clear both", v, 16'h0000);
    check("R12 irq low after both", {15'd0, irq[0]}, 16'd0);

    // R5 external pin falling edges
    wr(0, A_CTRL, mk(1, 2'b11, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'h0000);
    for (int n = 1; n <= 5; n++) begin
      ext_tick[0] = 1'b1;
      cycles(3);
      rd(0, A_CNT, v); check("R5 no count on rise", v, 16'(n - 1));
      ext_tick[0] = 1'b0;
      cycles(4);
      rd(0, A_CNT, v); check("R5 pin count", v, 16'(n));
    end

    // R10 capture edge modes on channel 1
    wr(1, A_CTRL, mk(0, 2'b01, 0, 0, 2'b01, 8'd0));
    wr(1, A_CNT, 16'h1234);
    ext_capture[1] = 1'b1; cycles(4);
    rd(1, A_CAPT, v); check("R10 rise capture", v, 16'h1234);
    rd(1, A_EVT, v);  check("R10 rise flag", v, 16'h0002);
    check("R12 capture irq", {15'd0, irq[1]}, 16'd1);
    ext_capture[1] = 1'b0; cycles(4);
    wr(1, A_EVT, 16'h0002);
    wr(1, A_CTRL, mk(0, 2'b01, 0, 0, 2'b10, 8'd0));
    wr(1, A_CNT, 16'h2222);
    ext_capture[1] = 1'b1; cycles(4);
    rd(1, A_CAPT, v); check("R10 fall mode ignores rise", v, 16'h1234);
    rd(1, A_EVT, v);  check("R10 fall mode no flag", v, 16'h0000);
    ext_capture[1] = 1'b0; cycles(4);
    rd(1, A_CAPT, v); check("R10 fall capture", v, 16'h2222);
    wr(1, A_EVT, 16'h0002);
    wr(1, A_CTRL, mk(0, 2'b01, 0, 0, 2'b11, 8'd0));
    wr(1, A_CNT, 16'h3333);
    ext_capture[1] = 1'b1; cycles(4);
    rd(1, A_CAPT, v); check("R10 any rise", v, 16'h3333);
    wr(1, A_CNT, 16'h4444);
    ext_capture[1] = 1'b0; cycles(4);
    rd(1, A_CAPT, v); check("R10 any fall", v, 16'h4444);
    wr(1, A_EVT, 16'h0002);
    wr(1, A_CTRL, mk(0, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(1, A_CNT, 16'h5555);
    ext_capture[1] = 1'b1; cycles(4);
    ext_capture[1] = 1'b0; cycles(4);
    rd(1, A_CAPT, v); check("R10 off keeps", v, 16'h4444);
    rd(1, A_EVT, v);  check("R10 off no flag", v, 16'h0000);

    // R7 gating on channel 1
    wr(1, A_CTRL, mk(1, 2'b01, 1, 0, 2'b00, 8'd0));
    wr(1, A_CNT, 16'h0000);
    cycles(10);
    rd(1, A_CNT, v); check("R7 gated off", v, 16'd0);
    ext_gate[1] = 1'b1;
    cycles(10);
    rd(1, A_CNT, v); check("R7 gated on", v, 16'd8);
    ext_gate[1] = 1'b0;
    wr(1, A_CTRL, mk(1, 2'b01, 0, 0, 2'b00, 8'd0));
    wr(1, A_CNT, 16'h0000);
    cycles(10);
    rd(1, A_CNT, v); check("R7 gate ignored", v, 16'd10);

    // R6 cascade: channel 0 counts channel 1 matches
    wr(1, A_CMP, 16'h0100);
    wr(1, A_CNT, 16'h0000);
    wr(0, A_CTRL, mk(1, 2'b00, 0, 0, 2'b00, 8'd0));
    wr(0, A_CNT, 16'h0000);
    for (int i = 1; i <= 3; i++) begin
      wr(1, A_CNT, 16'h00FC);
      cycles(8);
      rd(0, A_CNT, v); check("R6 cascade count", v, 16'(i));
    end
    rd(1, A_EVT, v); check("R9 channel 1 match", v, 16'h0001);
    wr(1, A_CTRL, mk(1, 2'b00, 0, 0, 2'b00, 8'd0));
    wr(1, A_CNT, 16'd7);
    cycles(20);
    rd(1, A_CNT, v); check("R6 channel 1 no cascade source", v, 16'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule